// File: doc/BRIEF.md
# Three-Wire Sampling Converter Front End with Power Modes

This block models the digital half of a serial sampling converter. A host drives a serial clock and a convert strobe; the block answers on one serial data line with an output enable. A 12-bit parallel input stands in for the analog core and is captured when a conversion begins. Every other timing is counted in cycles of a fast system clock. The serial clock and the strobe are treated as levels that are already synchronous to the system clock.

The same two host wires also select the power state. Strobe pulses that arrive while the serial clock is held low are counted, and certain counts lower the power state. A later rise of the serial clock raises it again. Coming up from the deepest state passes through a reference-settling interval. During that interval the block reports itself as napping, and any conversion returns a word of zeros. The first bit of every word is a ready flag, so the host can tell a valid result from a settling-period result.

Top module: `adc_pwr_emu`

## Requirements
- R1: After reset, `pwr_mode` reads 0 (active) and `sdo_oe` is low.
- R2: `pwr_mode` encodes 0 = active, 1 = nap, 2 = sleep. With `adc_clk` low, the falling strobe edge that completes the second counted pulse sets nap, and the one completing the fourth sets sleep. One pulse changes nothing.
- R3: A rising `adc_clk` while in a commanded nap returns the mode to active exactly NAP_WAKE_CYC system cycles after the system edge that sees the rise.
- R4: A rising `adc_clk` while asleep sets nap on that same edge. Active follows REF_SETTLE_CYC system cycles later. Sleep never goes straight to active, and active never goes straight to sleep.
- R5: A conversion whose strobe rises while the mode is not active yields 13 serial bits that are all zero, including the ready flag.
- R6: After a strobe rise, the 1st counted `adc_clk` rise drives the ready flag (1 when active), and rises 2 to 13 drive sample bits 11 down to 0. `sdo_oe` is high for those 13 bits and low from the 14th rise. The conversion ends on the 16th rise.
- R7: A strobe rise during a conversion neither restarts it nor recaptures `sample_in`.
- R8: `sdo` is 0 whenever `sdo_oe` is low, and `sdo_oe` is low outside a frame.
- R9: If the strobe rise precedes the first `adc_clk` rise by fewer than SETUP_CYC system cycles, that clock rise is skipped and the whole frame shifts one serial clock later.
- R10: Any `adc_clk` rise clears the strobe-pulse count, so pulses separated by a clock rise never add up to a power command.
- R11: A nap or sleep command cancels any pending or running conversion, so the clock rise that wakes the block drives no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that times all counters |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_clk | input | 1 | Host serial clock level |
| conv_in | input | 1 | Host convert strobe level |
| sample_in | input | DATA_W | Parallel stand-in for the analog result |
| sdo | output | 1 | Serial data, 0 while not enabled |
| sdo_oe | output | 1 | Output enable; low means high impedance |
| pwr_mode | output | 2 | Current power state (0 active, 1 nap, 2 sleep) |

## Verification
Random conversions use random samples and random strobe-to-clock gaps on both sides of the setup limit. This separates the normal frame alignment from the one-clock-late alignment and catches bit-order errors. Directed sequences issue one, two and four strobe pulses with the clock low. They tell the nap and sleep commands apart and pin down the exact wake-up cycle. Other directed cases send extra strobes in the middle of a frame, including two strobes split by a clock rise. These show whether the sample is recaptured and whether the pulse count is cleared. A conversion started during the settling nap tells the all-zero word apart from a valid one.

// File: rtl/adcpm_pkg.sv
// Shared types for the serial converter front end.
package adcpm_pkg;

    // Power states; the encoding is visible on the top-level port.
    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_NAP    = 2'd1,
        PM_SLEEP  = 2'd2
    } pm_mode_e;

endpackage

// File: rtl/adcpm_edge.sv
// Rise/fall detector for a group of host levels.
// Assumes the inputs are already synchronous to sys_clk. Each output pulse
// lasts one cycle: the cycle in which the new level is first seen.
module adcpm_edge #(
    parameter int N = 2
) (
    input  logic         sys_clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    // Keep last cycle's level of every input.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Compare the current level with the stored one, one input at a time.
        assign rise[i] = lvl[i] & ~prev_q[i];
        assign fall[i] = ~lvl[i] & prev_q[i];
    end

endmodule

// File: rtl/adcpm_power.sv
// Power-state controller.
// Counts strobe falls seen while the serial clock is low. At the NAP_PULSES
// count it commands nap, and at SLEEP_PULSES it commands sleep. A serial clock
// rise clears the count and starts the wake timer. Waking from sleep shows nap
// until the settling count expires. Assumes NAP_WAKE_CYC, REF_SETTLE_CYC >= 1.
module adcpm_power
    import adcpm_pkg::*;
#(
    parameter int NAP_WAKE_CYC   = 35,
    parameter int REF_SETTLE_CYC = 250000,
    parameter int NAP_PULSES     = 2,
    parameter int SLEEP_PULSES   = 4
) (
    input  logic     sys_clk,
    input  logic     rst_n,
    input  logic     clk_lvl,
    input  logic     clk_rise,
    input  logic     conv_fall,
    output pm_mode_e mode,
    output logic     pd_cmd
);

    localparam int WAKE_MAX = (NAP_WAKE_CYC > REF_SETTLE_CYC) ? NAP_WAKE_CYC : REF_SETTLE_CYC;
    localparam int TW       = $clog2(WAKE_MAX + 1);
    localparam int PCW      = $clog2(SLEEP_PULSES + 2);
    localparam logic [PCW-1:0] PC_MAX    = {PCW{1'b1}};
    localparam logic [PCW-1:0] PC_NAP    = PCW'(NAP_PULSES);
    localparam logic [PCW-1:0] PC_SLEEP  = PCW'(SLEEP_PULSES);
    localparam logic [TW-1:0]  NAP_LOAD  = TW'(NAP_WAKE_CYC - 1);
    localparam logic [TW-1:0]  REF_LOAD  = TW'(REF_SETTLE_CYC - 1);

    logic [PCW-1:0] pcnt_q, pcnt_nx;
    logic [TW-1:0]  wcnt_q;
    logic           waking_q;
    logic           pulse_seen, cmd_nap, cmd_sleep;

    // Decode the power command that the current strobe fall would complete.
    always_comb begin
        pulse_seen = conv_fall && !clk_lvl;
        pcnt_nx    = (pcnt_q == PC_MAX) ? pcnt_q : pcnt_q + 1'b1;
        cmd_nap    = pulse_seen && (pcnt_nx == PC_NAP);
        cmd_sleep  = pulse_seen && (pcnt_nx == PC_SLEEP);
        pd_cmd     = cmd_nap || cmd_sleep;
    end

    // Pulse counter: cleared by a serial clock rise, bumped by low-clock pulses.
    always_ff @(posedge sys_clk) begin
        if (!rst_n)          pcnt_q <= '0;
        else if (clk_rise)   pcnt_q <= '0;
        else if (pulse_seen) pcnt_q <= pcnt_nx;
    end

    // Mode register with the wake timer; a command overrides a wake in progress.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            mode     <= PM_ACTIVE;
            waking_q <= 1'b0;
            wcnt_q   <= '0;
        end else if (cmd_sleep) begin
            mode     <= PM_SLEEP;
            waking_q <= 1'b0;
        end else if (cmd_nap) begin
            mode     <= PM_NAP;
            waking_q <= 1'b0;
        end else if (clk_rise && mode != PM_ACTIVE && !waking_q) begin
            waking_q <= 1'b1;
            wcnt_q   <= (mode == PM_SLEEP) ? REF_LOAD : NAP_LOAD;
            mode     <= PM_NAP;
        end else if (waking_q) begin
            if (wcnt_q == '0) begin
                mode     <= PM_ACTIVE;
                waking_q <= 1'b0;
            end else begin
                wcnt_q   <= wcnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/adcpm_shifter.sv
// Conversion frame engine.
// A strobe rise while idle captures the word: the ready flag followed by the
// sample when ready_in is high, or all zeros otherwise. Counted serial clock
// rises shift the word out MSB first. The first rise is not counted if it
// comes sooner than SETUP_CYC system cycles after the strobe. The frame ends
// after FRAME_CLKS counted rises. Assumes SETUP_CYC >= 1 and
// FRAME_CLKS > DATA_W + 1.
module adcpm_shifter #(
    parameter int DATA_W     = 12,
    parameter int FRAME_CLKS = 16,
    parameter int SETUP_CYC  = 4
) (
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic              conv_rise,
    input  logic              clk_rise,
    input  logic              abort,
    input  logic              ready_in,
    input  logic [DATA_W-1:0] sample,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int WORD_BITS = DATA_W + 1;
    localparam int BCW       = $clog2(FRAME_CLKS + 1);
    localparam int SCW       = $clog2(SETUP_CYC + 1);
    localparam logic [BCW-1:0] LAST_DATA = BCW'(WORD_BITS);
    localparam logic [BCW-1:0] LAST_CLK  = BCW'(FRAME_CLKS - 1);
    localparam logic [SCW-1:0] SETUP_LIM = SCW'(SETUP_CYC);

    logic                 busy_q, started_q;
    logic [SCW-1:0]       setup_q;
    logic [BCW-1:0]       bit_q;
    logic [WORD_BITS-1:0] word_q;

    // Frame sequencing: capture, setup check, shift, release, finish.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            started_q <= 1'b0;
            setup_q   <= '0;
            bit_q     <= '0;
            word_q    <= '0;
            sdo       <= 1'b0;
            sdo_oe    <= 1'b0;
        end else if (abort) begin
            busy_q    <= 1'b0;
            started_q <= 1'b0;
            sdo       <= 1'b0;
            sdo_oe    <= 1'b0;
        end else if (!busy_q) begin
            if (conv_rise) begin
                busy_q    <= 1'b1;
                started_q <= 1'b0;
                setup_q   <= SCW'(1);
                bit_q     <= '0;
                word_q    <= ready_in ? {1'b1, sample} : '0;
            end
        end else if (!started_q) begin
            if (setup_q != SETUP_LIM) setup_q <= setup_q + 1'b1;
            if (clk_rise && setup_q == SETUP_LIM) begin
                started_q <= 1'b1;
                bit_q     <= BCW'(1);
                sdo_oe    <= 1'b1;
                sdo       <= word_q[WORD_BITS-1];
                word_q    <= word_q << 1;
            end
        end else if (clk_rise) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q < LAST_DATA) begin
                sdo    <= word_q[WORD_BITS-1];
                word_q <= word_q << 1;
            end else begin
                sdo    <= 1'b0;
                sdo_oe <= 1'b0;
            end
            if (bit_q == LAST_CLK) begin
                busy_q    <= 1'b0;
                started_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_pwr_emu.sv
// Top level of the serial converter front end.
// Ties the edge detector, the power controller and the frame engine together.
// Assumes adc_clk and conv_in change synchronously to sys_clk.
module adc_pwr_emu
    import adcpm_pkg::*;
#(
    parameter int DATA_W         = 12,
    parameter int FRAME_CLKS     = 16,
    parameter int SETUP_CYC      = 4,
    parameter int NAP_WAKE_CYC   = 35,
    parameter int REF_SETTLE_CYC = 250000
) (
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic              adc_clk,
    input  logic              conv_in,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [1:0]        pwr_mode
);

    localparam int CONV_IDX = 0;
    localparam int CLK_IDX  = 1;

    logic [1:0] rise_w, fall_w;
    logic       clk_rise_w, conv_rise_w, conv_fall_w, abort_w;
    pm_mode_e   mode_w;

    adcpm_edge #(.N(2)) u_edge (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .lvl     ({adc_clk, conv_in}),
        .rise    (rise_w),
        .fall    (fall_w)
    );

    assign clk_rise_w  = rise_w[CLK_IDX];
    assign conv_rise_w = rise_w[CONV_IDX];
    assign conv_fall_w = fall_w[CONV_IDX];

    adcpm_power #(
        .NAP_WAKE_CYC   (NAP_WAKE_CYC),
        .REF_SETTLE_CYC (REF_SETTLE_CYC),
        .NAP_PULSES     (2),
        .SLEEP_PULSES   (4)
    ) u_power (
        .sys_clk   (sys_clk),
        .rst_n     (rst_n),
        .clk_lvl   (adc_clk),
        .clk_rise  (clk_rise_w),
        .conv_fall (conv_fall_w),
        .mode      (mode_w),
        .pd_cmd    (abort_w)
    );

    adcpm_shifter #(
        .DATA_W     (DATA_W),
        .FRAME_CLKS (FRAME_CLKS),
        .SETUP_CYC  (SETUP_CYC)
    ) u_shift (
        .sys_clk   (sys_clk),
        .rst_n     (rst_n),
        .conv_rise (conv_rise_w),
        .clk_rise  (clk_rise_w),
        .abort     (abort_w),
        .ready_in  (mode_w == PM_ACTIVE),
        .sample    (sample_in),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    assign pwr_mode = mode_w;

endmodule

// File: rtl/adc_pwr_emu_chk.sv
// Temporal checks on the front end, bound to every instance of the top module.
module adc_pwr_emu_chk (
    input logic       sys_clk,
    input logic       rst_n,
    input logic       sdo,
    input logic       sdo_oe,
    input logic [1:0] pwr_mode,
    input logic       clk_rise,
    input logic       abort
);

    // R8
    sdo_quiet_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    // R2
    mode_code_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        pwr_mode != 2'd3);

    // R4
    active_exit_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (pwr_mode == 2'd0) |=> (pwr_mode != 2'd2));

    // R4
    sleep_exit_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (pwr_mode == 2'd2) |=> (pwr_mode != 2'd0));

    // R6
    sdo_timing_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (!$stable(sdo_oe) || !$stable(sdo)) |-> $past(clk_rise || abort));

endmodule

bind adc_pwr_emu adc_pwr_emu_chk u_chk (
    .sys_clk  (sys_clk),
    .rst_n    (rst_n),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .pwr_mode (pwr_mode),
    .clk_rise (clk_rise_w),
    .abort    (abort_w)
);

// File: tb/test_adc_pwr_emu.sv
module test_adc_pwr_emu;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 12;
    localparam int NAP_W      = 12;
    localparam int SETTLE     = 300;
    localparam int SETUP      = 4;

    logic          sys_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic          adc_clk = 1'b0;
    logic          conv_in = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic          sdo, sdo_oe;
    logic [1:0]    pwr_mode;

    int checks = 0;
    int fails  = 0;
    logic [17:0] obs_oe, obs_sd;

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

    adc_pwr_emu #(
        .DATA_W (DW), .FRAME_CLKS (16), .SETUP_CYC (SETUP),
        .NAP_WAKE_CYC (NAP_W), .REF_SETTLE_CYC (SETTLE)
    ) i_adc_pwr_emu (
        .sys_clk (sys_clk), .rst_n (rst_n), .adc_clk (adc_clk),
        .conv_in (conv_in), .sample_in (sample_in),
        .sdo (sdo), .sdo_oe (sdo_oe), .pwr_mode (pwr_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [12:0] exp_word(input bit rdy, input logic [DW-1:0] s);
        return rdy ? {1'b1, s} : 13'd0;
    endfunction

    // One strobe pulse with the serial clock held low.
    task automatic pd_pulse();
        conv_in = 1'b1; repeat (2) @(negedge sys_clk);
        conv_in = 1'b0; repeat (2) @(negedge sys_clk);
    endtask

    // Strobe, wait gap cycles, then 17 serial clocks; optional strobes at low phases 5 and 6.
    task automatic convert(input int gap, input bit mid);
        conv_in = 1'b1;
        repeat (gap) @(negedge sys_clk);
        for (int k = 1; k <= 17; k++) begin
            adc_clk = 1'b1; repeat (2) @(negedge sys_clk);
            conv_in = 1'b0; repeat (2) @(negedge sys_clk);
            obs_oe[k] = sdo_oe;
            obs_sd[k] = sdo;
            adc_clk = 1'b0;
            if (mid && (k == 5 || k == 6)) begin
                sample_in = ~sample_in;
                conv_in = 1'b1; @(negedge sys_clk);
                conv_in = 1'b0; repeat (3) @(negedge sys_clk);
            end else begin
                repeat (4) @(negedge sys_clk);
            end
        end
    endtask

    task automatic check_frame(input logic [12:0] w, input int d, input string req);
        for (int k = 1; k <= 17; k++) begin
            int  j    = k - d;
            bit  e_oe = (j >= 1 && j <= 13);
            bit  e_sd = e_oe ? w[13 - j] : 1'b0;
            chk(obs_oe[k] == e_oe, {req, " oe"}, obs_oe[k], e_oe);
            chk(obs_sd[k] == e_sd, {req, " sdo"}, obs_sd[k], e_sd);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge sys_clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] s;
        void'($urandom(32'd2024));
        repeat (3) @(negedge sys_clk);
        rst_n = 1'b1;
        @(negedge sys_clk);
        // R1 reset state
        chk(pwr_mode == 2'd0, "R1 mode", pwr_mode, 0);
        chk(sdo_oe == 1'b0, "R1 oe", sdo_oe, 0);
        chk(sdo == 1'b0, "R8 idle sdo", sdo, 0);

        // R6 R9 random conversions with random gaps
        for (int n = 0; n < 10; n++) begin
            int g = 1 + int'($urandom % 8);
            s = DW'($urandom);
            sample_in = s;
            convert(g, 1'b0);
            check_frame(exp_word(1'b1, s), (g < SETUP) ? 1 : 0, (g < SETUP) ? "R9" : "R6");
        end

        // R7 R10 strobes inside a frame, split by a clock rise
        s = 12'hA5C; sample_in = s;
        convert(6, 1'b1);
        check_frame(exp_word(1'b1, s), 0, "R7");
        chk(pwr_mode == 2'd0, "R10 mode", pwr_mode, 0);

        // R2 R3 R11 nap and exact wake
        pd_pulse();
        chk(pwr_mode == 2'd0, "R2 one pulse", pwr_mode, 0);
        pd_pulse();
        chk(pwr_mode == 2'd1, "R2 nap", pwr_mode, 1);
        adc_clk = 1'b1;
        repeat (NAP_W) @(negedge sys_clk);
        chk(pwr_mode == 2'd1, "R3 still nap", pwr_mode, 1);
        @(negedge sys_clk);
        chk(pwr_mode == 2'd0, "R3 awake", pwr_mode, 0);
        chk(sdo_oe == 1'b0, "R11 no data", sdo_oe, 0);
        adc_clk = 1'b0; repeat (4) @(negedge sys_clk);

        // R2 R4 R5 R11 sleep, settling nap, zero word
        for (int p = 1; p <= 4; p++) begin
            pd_pulse();
            if (p == 2) chk(pwr_mode == 2'd1, "R2 nap step", pwr_mode, 1);
        end
        chk(pwr_mode == 2'd2, "R2 sleep", pwr_mode, 2);
        adc_clk = 1'b1; @(negedge sys_clk);
        chk(pwr_mode == 2'd1, "R4 auto nap", pwr_mode, 1);
        chk(sdo_oe == 1'b0, "R11 aborted", sdo_oe, 0);
        adc_clk = 1'b0; repeat (4) @(negedge sys_clk);
        s = 12'hFFF; sample_in = s;
        convert(6, 1'b0);
        check_frame(13'd0, 0, "R5");
        chk(pwr_mode == 2'd1, "R4 settling", pwr_mode, 1);
        repeat (SETTLE) @(negedge sys_clk);
        chk(pwr_mode == 2'd0, "R4 active", pwr_mode, 0);
        s = 12'h801; sample_in = s;
        convert(SETUP, 1'b0);
        check_frame(exp_word(1'b1, s), 0, "R6 after wake");
        convert(SETUP - 1, 1'b0);
        check_frame(exp_word(1'b1, s), 1, "R9 edge");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule